// File: doc/BRIEF.md
# Work RAM Access Gate

This block decides whether a CPU access that lands in the 0x6000-0x7FFF work RAM window may reach the RAM, and it forms the RAM-side address. Two control registers are loaded over a small register-write port. A variant input picks between two layouts. The standard layout places an 8 KB RAM across the whole window, with a single enable and a single write-protect. The alternate layout places a 1 KB RAM in 0x7000-0x7FFF. That RAM repeats every 1 KB and is split into two 512-byte pages. Each page has its own read and write permission, and a master enable overrides both.

The outputs are combinational in the CPU address and strobes. The RAM select and write enable can therefore drive the RAM directly in the same cycle. A read that is denied leaves the bus undriven and is reported by a low read-data-valid. Register writes take effect on the next rising clock edge.

Top module: `work_ram_gate`

## Requirements
- R1: After reset both control registers are zero, so every access in either variant produces no RAM select, no write enable and no read-data-valid.
- R2: In the standard variant, when protect-register bit 7 is 1, a read anywhere in 0x6000-0x7FFF asserts RAM select and read-data-valid, with RAM address equal to CPU address bits 12:0.
- R3: In the standard variant a write asserts RAM select and write enable only when protect-register bit 7 is 1 and bit 6 is 0. When bit 6 is 1 the write produces neither.
- R4: In the standard variant, when protect-register bit 7 is 0, nothing in the window responds. The mode register has no effect in this variant.
- R5: In the alternate variant, when mode-register bit 5 is 0, both pages deny reads and writes whatever the protect register holds.
- R6: In the alternate variant, with the master enable set, protect-register bit 4 permits writes and bit 5 permits reads to the first page. Bit 6 permits writes and bit 7 permits reads to the second page.
- R7: In the alternate variant only 0x7000-0x7FFF responds. The RAM address is CPU address bits 9:0, zero-extended, so the 1 KB repeats every 1 KB. Address bit 9 selects the page (0 = first, 1 = second).
- R8: In the alternate variant, 0x6000-0x6FFF gives no RAM select. In either variant, addresses outside 0x6000-0x7FFF give no RAM select.
- R9: A register write with select 0 loads the mode register and with select 1 loads the protect register. It takes effect at the next clock edge and leaves the other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regSel | input | 1 | 0 = mode register, 1 = protect register |
| regHiData | input | 4 | Bits 7..4 of the written byte (lower bits carry no function) |
| altMode | input | 1 | 0 = standard 8 KB layout, 1 = alternate 1 KB paged layout |
| cpuAddr | input | 16 | CPU address |
| cpuRd | input | 1 | CPU read strobe |
| cpuWr | input | 1 | CPU write strobe |
| ramCs | output | 1 | RAM chip select |
| ramWe | output | 1 | RAM write enable |
| ramAddr | output | 13 | RAM address |
| rdValid | output | 1 | Read data valid (low means the bus is left undriven) |

## Verification
The bench builds the block with its default parameters: a 16-bit CPU address, a 13-bit RAM address and two 512-byte alternate pages. With these values both windows sit at their fixed addresses. The bench can then probe both ends of each window, the 0x6000-0x6FFF gap in the alternate layout, and a mirrored copy at 0x7C00. Every permission combination of the two pages is reached by loading the protect register with values that split read and write rights across the pages.

// File: rtl/work_ram_pkg.sv
package work_ram_pkg;
  localparam int ALT_PAGES = 2;

  typedef struct packed {
    logic                 stdRd;
    logic                 stdWr;
    logic [ALT_PAGES-1:0] altRd;
    logic [ALT_PAGES-1:0] altWr;
  } permStrobes_t;
endpackage

// File: rtl/work_ram_ctrl.sv
module work_ram_ctrl
  import work_ram_pkg::*;
#(
  parameter int FIELD_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWr,
  input  logic               regSel,
  input  logic [FIELD_W-1:0] regHiData,
  output permStrobes_t       perm
);
  // Field positions are relative to bit 4 of the written byte.
  localparam int MASTER_POS = 1;  // byte bit 5 of the mode register
  localparam int STD_WP_POS = 2;  // byte bit 6
  localparam int STD_EN_POS = 3;  // byte bit 7

  logic               masterEn;
  logic [FIELD_W-1:0] protReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      masterEn <= 1'b0;
      protReg  <= '0;
    end else if (regWr) begin
      if (regSel) protReg  <= regHiData;
      else        masterEn <= regHiData[MASTER_POS];
    end
  end

  always_comb begin
    perm.stdRd = protReg[STD_EN_POS];
    perm.stdWr = protReg[STD_EN_POS] & ~protReg[STD_WP_POS];
  end

  // Each page owns a write bit at even offset and a read bit just above it.
  for (genvar p = 0; p < ALT_PAGES; p++) begin : g_page
    assign perm.altWr[p] = masterEn & protReg[2*p];
    assign perm.altRd[p] = masterEn & protReg[2*p+1];
  end

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (perm == '0));
  a_r5_master_off: assert property (@(posedge clk) disable iff (!rstN)
    !masterEn |-> (perm.altRd == '0 && perm.altWr == '0));
  a_r9_other_reg_kept: assert property (@(posedge clk) disable iff (!rstN)
    ($past(regWr) && !$past(regSel)) |-> $stable(protReg));
endmodule

// File: rtl/work_ram_path.sv
module work_ram_path
  import work_ram_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int RAM_AW  = 13,
  parameter int ALT_AW  = 10,
  parameter int ALT_WIN = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              altMode,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuRd,
  input  logic              cpuWr,
  input  permStrobes_t      perm,
  output logic              ramCs,
  output logic              ramWe,
  output logic [RAM_AW-1:0] ramAddr,
  output logic              rdValid
);
  localparam int PAGE_BITS = $clog2(ALT_PAGES);
  localparam logic [ADDR_W-RAM_AW-1:0]  STD_TAG = (ADDR_W-RAM_AW)'(16'h6000 >> RAM_AW);
  localparam logic [ADDR_W-ALT_WIN-1:0] ALT_TAG = (ADDR_W-ALT_WIN)'(16'h7000 >> ALT_WIN);

  logic                 inStd, inAlt, inWin;
  logic [PAGE_BITS-1:0] pageIdx;
  logic                 mayRd, mayWr, rdOk, wrOk;

  always_comb begin
    inStd   = cpuAddr[ADDR_W-1:RAM_AW] == STD_TAG;
    inAlt   = cpuAddr[ADDR_W-1:ALT_WIN] == ALT_TAG;
    pageIdx = cpuAddr[ALT_AW-1 -: PAGE_BITS];
    if (altMode) begin
      inWin   = inAlt;
      mayRd   = perm.altRd[pageIdx];
      mayWr   = perm.altWr[pageIdx];
      ramAddr = RAM_AW'(cpuAddr[ALT_AW-1:0]);
    end else begin
      inWin   = inStd;
      mayRd   = perm.stdRd;
      mayWr   = perm.stdWr;
      ramAddr = cpuAddr[RAM_AW-1:0];
    end
    rdOk    = inWin & cpuRd & mayRd;
    wrOk    = inWin & cpuWr & mayWr;
    ramCs   = rdOk | wrOk;
    ramWe   = wrOk;
    rdValid = rdOk;
  end

  a_r3_we_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (cpuWr && ramCs));
  a_r2_valid_needs_read: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (cpuRd && ramCs));
  a_r8_std_outside: assert property (@(posedge clk) disable iff (!rstN)
    (!altMode && cpuAddr[ADDR_W-1:RAM_AW] != STD_TAG) |-> !ramCs);
  a_r8_alt_outside: assert property (@(posedge clk) disable iff (!rstN)
    (altMode && cpuAddr[ADDR_W-1:ALT_WIN] != ALT_TAG) |-> !ramCs);
  a_r7_alt_addr_range: assert property (@(posedge clk) disable iff (!rstN)
    altMode |-> (ramAddr < RAM_AW'(1 << ALT_AW)));
endmodule

// File: rtl/work_ram_gate.sv
module work_ram_gate
  import work_ram_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int RAM_AW = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regSel,
  input  logic [3:0]        regHiData,
  input  logic              altMode,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuRd,
  input  logic              cpuWr,
  output logic              ramCs,
  output logic              ramWe,
  output logic [RAM_AW-1:0] ramAddr,
  output logic              rdValid
);
  permStrobes_t perm;

  work_ram_ctrl #(.FIELD_W(4)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel),
    .regHiData(regHiData), .perm(perm)
  );

  work_ram_path #(.ADDR_W(ADDR_W), .RAM_AW(RAM_AW)) u_path (
    .clk(clk), .rstN(rstN), .altMode(altMode), .cpuAddr(cpuAddr),
    .cpuRd(cpuRd), .cpuWr(cpuWr), .perm(perm), .ramCs(ramCs),
    .ramWe(ramWe), .ramAddr(ramAddr), .rdValid(rdValid)
  );
endmodule

// File: tb/sim_work_ram_gate.sv
module sim_work_ram_gate;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0, regSel = 1'b0;
  logic [3:0]  regHiData = '0;
  logic        altMode = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic        cpuRd = 1'b0, cpuWr = 1'b0;
  logic        ramCs, ramWe, rdValid;
  logic [12:0] ramAddr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  work_ram_gate u0 (.*);

  task automatic writeReg(input logic sel, input logic [7:0] val);
    @(negedge clk);
    regWr = 1'b1; regSel = sel; regHiData = val[7:4];
    @(negedge clk);
    regWr = 1'b0;
  endtask

  // Drives one access, checks the outputs mid-cycle. expAddr < 0 means don't care.
  task automatic probe(input string tag, input logic [15:0] a, input logic rd, input logic wr,
                       input logic eCs, input logic eWe, input logic eVal, input int expAddr);
    @(negedge clk);
    cpuAddr = a; cpuRd = rd; cpuWr = wr;
    #5;
    checks++;
    if (ramCs !== eCs || ramWe !== eWe || rdValid !== eVal ||
        (expAddr >= 0 && ramAddr !== 13'(expAddr))) begin
      errors++;
      $display("FAIL %s addr=%h: cs/we/val/ramAddr = %b%b%b/%h expected %b%b%b/%h",
               tag, a, ramCs, ramWe, rdValid, ramAddr, eCs, eWe, eVal, expAddr);
    end
    cpuRd = 1'b0; cpuWr = 1'b0;
  endtask

  task automatic testReset();
    altMode = 1'b0;
    probe("R1 std read", 16'h6000, 1, 0, 0, 0, 0, -1);
    probe("R1 std write", 16'h7FFF, 0, 1, 0, 0, 0, -1);
    altMode = 1'b1;
    probe("R1 alt read", 16'h7000, 1, 0, 0, 0, 0, -1);
    altMode = 1'b0;
  endtask

  task automatic testStandard();
    altMode = 1'b0;
    writeReg(1, 8'h80);
    probe("R2 read", 16'h6123, 1, 0, 1, 0, 1, 13'h0123);
    probe("R2 read top", 16'h7FFF, 1, 0, 1, 0, 1, 13'h1FFF);
    probe("R3 write", 16'h7ABC, 0, 1, 1, 1, 0, 13'h1ABC);
    probe("R8 std outside", 16'h8000, 1, 0, 0, 0, 0, -1);
    probe("R8 std below", 16'h5FFF, 0, 1, 0, 0, 0, -1);
    writeReg(1, 8'hC0);
    probe("R3 protected write", 16'h6010, 0, 1, 0, 0, 0, -1);
    probe("R2 read while protected", 16'h6010, 1, 0, 1, 0, 1, 13'h0010);
    writeReg(1, 8'h40);
    probe("R4 disabled read", 16'h6200, 1, 0, 0, 0, 0, -1);
    writeReg(0, 8'h20);
    probe("R4 mode reg no effect", 16'h6200, 1, 0, 0, 0, 0, -1);
    writeReg(0, 8'h00);
  endtask

  task automatic testAlternate();
    altMode = 1'b1;
    writeReg(1, 8'hF0);
    probe("R5 master off read", 16'h7000, 1, 0, 0, 0, 0, -1);
    probe("R5 master off write", 16'h7200, 0, 1, 0, 0, 0, -1);
    writeReg(0, 8'h20);
    probe("R6 page0 read", 16'h7005, 1, 0, 1, 0, 1, 13'h005);
    probe("R6 page1 write", 16'h7205, 0, 1, 1, 1, 0, 13'h205);
    probe("R7 mirror", 16'h7C10, 1, 0, 1, 0, 1, 13'h010);
    probe("R7 mirror page1", 16'h7FFF, 1, 0, 1, 0, 1, 13'h3FF);
    probe("R8 alt low window", 16'h6000, 1, 0, 0, 0, 0, -1);
    probe("R8 alt 6FFF", 16'h6FFF, 0, 1, 0, 0, 0, -1);
    writeReg(1, 8'h90); // page0 write only, page1 read only
    probe("R6 page0 write ok", 16'h7010, 0, 1, 1, 1, 0, 13'h010);
    probe("R6 page0 read denied", 16'h7010, 1, 0, 0, 0, 0, -1);
    probe("R6 page1 read ok", 16'h7210, 1, 0, 1, 0, 1, 13'h210);
    probe("R6 page1 write denied", 16'h7210, 0, 1, 0, 0, 0, -1);
    writeReg(1, 8'h60); // page0 read only, page1 write only
    probe("R6 page0 read ok", 16'h7410, 1, 0, 1, 0, 1, 13'h010);
    probe("R6 page1 write ok", 16'h7610, 0, 1, 1, 1, 0, 13'h210);
    probe("R6 page1 read denied", 16'h7610, 1, 0, 0, 0, 0, -1);
  endtask

  task automatic testRegSelect();
    altMode = 1'b1;
    writeReg(1, 8'h80);          // page1 read only
    writeReg(0, 8'h00);          // master off; protect must be kept
    probe("R9 master cleared", 16'h7200, 1, 0, 0, 0, 0, -1);
    writeReg(0, 8'h20);
    probe("R9 protect kept", 16'h7200, 1, 0, 1, 0, 1, 13'h200);
    // Register write not yet clocked has no effect.
    @(negedge clk);
    regWr = 1'b1; regSel = 1'b1; regHiData = 4'h0;
    cpuAddr = 16'h7200; cpuRd = 1'b1;
    #5;
    checks++;
    if (rdValid !== 1'b1) begin
      errors++;
      $display("FAIL R9 before edge: rdValid=%b expected 1", rdValid);
    end
    @(negedge clk);
    regWr = 1'b0;
    #5;
    checks++;
    if (rdValid !== 1'b0) begin
      errors++;
      $display("FAIL R9 after edge: rdValid=%b expected 0", rdValid);
    end
    cpuRd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testStandard();
    testAlternate();
    testRegSelect();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not complete");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule